// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

This block watches the byte stream that a receive MAC hands upward and raises a wake flag when a received frame carries a magic packet for this station. A magic packet is an ordinary Ethernet frame with destination and source fields and a trailing CRC. Somewhere in its payload it holds a run of six 0xFF bytes, followed at once by sixteen unbroken repetitions of the station's 48-bit address.

The block keeps the byte-level matching state for one frame at a time and clears it at every start of frame. It decides at end of frame whether to wake, using the receive path's CRC verdict and the current power state. Detection follows an enable bit in full power, is always on in the first low-power state, and is off in every deeper state. The wake flag holds until a clear pulse. Framing, CRC computation and pattern-based wake filters belong to the surrounding receive path.

Top module: `wol_magic_detect`

## Requirements
- R1: A frame wakes the block when its bytes hold at least six consecutive 0xFF bytes followed immediately by 16 back-to-back copies of the station address, each copy sent most significant byte first (station_addr[47:40] first). The sequence must be complete before the end-of-frame byte, and a run of only five 0xFF bytes does not qualify.
- R2: A frame with fewer than 16 copies, or with any foreign byte between copies, does not wake the block.
- R3: A frame whose end-of-frame byte arrives with rx_crc_ok low does not wake the block.
- R4: With pwr_state = 2'b00 (full power), a frame wakes the block only when magic_en is 1.
- R5: With pwr_state = 2'b01 (first low-power state), a frame wakes the block whatever magic_en holds.
- R6: With pwr_state = 2'b10 or 2'b11, no frame wakes the block.
- R7: The sync run may start at any payload offset and may be longer than six bytes. A 0xFF byte that breaks a partial address match counts as the first byte of a new sync run.
- R8: wake_flag rises in the cycle after the clock edge that accepts the qualifying end-of-frame byte. It stays 1 until wake_clr is sampled high, and a wake event in the same cycle as wake_clr wins.
- R9: A start-of-frame byte discards all matching progress, so a sequence completed in an earlier frame never wakes the block at a later frame's end.
- R10: After reset, wake_flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_byte | input | 8 | Receive byte |
| rx_sof | input | 1 | With rx_valid: first byte of a frame |
| rx_eof | input | 1 | With rx_valid: last byte of a frame |
| rx_crc_ok | input | 1 | With rx_eof: frame CRC was good |
| station_addr | input | 48 | Local station address |
| magic_en | input | 1 | Detection enable in full power |
| pwr_state | input | 2 | 00 full power, 01 first low-power, 10/11 deeper |
| wake_clr | input | 1 | Clears the wake flag |
| wake_flag | output | 1 | Sticky wake indication |

## Verification
The assertions assume that rx_sof and rx_eof are meaningful only when rx_valid is high, and that rx_crc_ok is settled in the end-of-frame cycle. They also assume that station_addr and pwr_state stay constant across a frame. The bench drives every frame as one contiguous burst of valid bytes that opens with rx_sof and closes with rx_eof. It changes the address, the enable and the power state only between frames, and it keeps 0xFF out of the station address, headers and CRC bytes so that the only sync runs are the ones a scenario places on purpose.

// File: rtl/wol_pkg.sv
package wol_pkg;

    localparam int SYNC_RUN_DEF   = 6;
    localparam int ADDR_BYTES_DEF = 6;
    localparam int COPIES_DEF     = 16;
    localparam logic [7:0] SYNC_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        PWR_FULL  = 2'b00,
        PWR_LOW1  = 2'b01,
        PWR_LOW2  = 2'b10,
        PWR_LOW3  = 2'b11
    } pwr_state_e;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_ADDR = 2'd1,
        PH_DONE = 2'd2
    } match_phase_e;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic       crc_ok;
        logic [7:0] data;
    } rx_beat_t;

    function automatic logic detect_armed(input pwr_state_e ps, input logic en);
        case (ps)
            PWR_FULL: return en;
            PWR_LOW1: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wol_arm_gate.sv
module wol_arm_gate
    import wol_pkg::*;
(
    input  logic [1:0] pwr_state,
    input  logic       magic_en,
    output logic       armed
);
    pwr_state_e ps;

    always_comb begin
        ps    = pwr_state_e'(pwr_state);
        armed = detect_armed(ps, magic_en);
    end
endmodule

// File: rtl/wol_seq_matcher.sv
module wol_seq_matcher
    import wol_pkg::*;
#(
    parameter int SYNC_RUN   = SYNC_RUN_DEF,
    parameter int ADDR_BYTES = ADDR_BYTES_DEF,
    parameter int COPIES     = COPIES_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  rx_beat_t                beat,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    match_done
);
    localparam int SW = $clog2(SYNC_RUN + 1);
    localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int CW = (COPIES > 1) ? $clog2(COPIES) : 1;
    localparam logic [SW-1:0] SYNC_LAST = SW'(SYNC_RUN - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(ADDR_BYTES - 1);
    localparam logic [CW-1:0] COPY_LAST = CW'(COPIES - 1);

    typedef struct packed {
        match_phase_e  phase;
        logic [SW-1:0] ff_cnt;
        logic [IW-1:0] byte_idx;
        logic [CW-1:0] copy_idx;
    } match_state_t;

    localparam match_state_t IDLE_ST = '{phase: PH_SYNC, ff_cnt: '0, byte_idx: '0, copy_idx: '0};

    match_state_t cur, base, nxt;
    logic [7:0]   want;
    logic         is_sync;

    always_comb begin
        base    = beat.sof ? IDLE_ST : cur;
        want    = station_addr[(ADDR_BYTES - 1 - int'(base.byte_idx)) * 8 +: 8];
        is_sync = (beat.data == SYNC_BYTE);
        nxt     = cur;
        if (beat.valid) begin
            nxt = base;
            case (base.phase)
                PH_SYNC: begin
                    if (!is_sync) begin
                        nxt.ff_cnt = '0;
                    end else if (base.ff_cnt == SYNC_LAST) begin
                        nxt.phase    = PH_ADDR;
                        nxt.ff_cnt   = '0;
                        nxt.byte_idx = '0;
                        nxt.copy_idx = '0;
                    end else begin
                        nxt.ff_cnt = base.ff_cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    if (beat.data == want) begin
                        if (base.byte_idx == IDX_LAST) begin
                            nxt.byte_idx = '0;
                            if (base.copy_idx == COPY_LAST) begin
                                nxt.phase = PH_DONE;
                            end else begin
                                nxt.copy_idx = base.copy_idx + 1'b1;
                            end
                        end else begin
                            nxt.byte_idx = base.byte_idx + 1'b1;
                        end
                    end else if (is_sync && base.byte_idx == '0 && base.copy_idx == '0) begin
                        // sync run longer than the minimum: remain waiting for copy zero
                        nxt = base;
                    end else if (is_sync) begin
                        nxt        = IDLE_ST;
                        nxt.ff_cnt = SW'(1);
                    end else begin
                        nxt = IDLE_ST;
                    end
                end
                PH_DONE: nxt = base;
                default: nxt = IDLE_ST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= IDLE_ST;
        else     cur <= nxt;
    end

    assign match_done = (cur.phase == PH_DONE);
endmodule

// File: rtl/wol_wake_latch.sv
module wol_wake_latch
    import wol_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_beat_t beat,
    input  logic     armed,
    input  logic     match_done,
    input  logic     wake_clr,
    output logic     wake_flag
);
    logic hit;

    always_comb begin
        hit = beat.valid && beat.eof && beat.crc_ok && armed && match_done && !beat.sof;
    end

    always_ff @(posedge clk) begin
        if (rst)           wake_flag <= 1'b0;
        else if (hit)      wake_flag <= 1'b1;
        else if (wake_clr) wake_flag <= 1'b0;
    end
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect
    import wol_pkg::*;
#(
    parameter int SYNC_RUN   = SYNC_RUN_DEF,
    parameter int ADDR_BYTES = ADDR_BYTES_DEF,
    parameter int COPIES     = COPIES_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic                    rx_crc_ok,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    magic_en,
    input  logic [1:0]              pwr_state,
    input  logic                    wake_clr,
    output logic                    wake_flag
);
    rx_beat_t beat;
    logic     armed;
    logic     match_done;

    always_comb begin
        beat.valid  = rx_valid;
        beat.sof    = rx_sof;
        beat.eof    = rx_eof;
        beat.crc_ok = rx_crc_ok;
        beat.data   = rx_byte;
    end

    wol_arm_gate u_arm (
        .pwr_state (pwr_state),
        .magic_en  (magic_en),
        .armed     (armed)
    );

    wol_seq_matcher #(
        .SYNC_RUN   (SYNC_RUN),
        .ADDR_BYTES (ADDR_BYTES),
        .COPIES     (COPIES)
    ) u_match (
        .clk          (clk),
        .rst          (rst),
        .beat         (beat),
        .station_addr (station_addr),
        .match_done   (match_done)
    );

    wol_wake_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .beat       (beat),
        .armed      (armed),
        .match_done (match_done),
        .wake_clr   (wake_clr),
        .wake_flag  (wake_flag)
    );
endmodule

// File: rtl/wol_magic_detect_chk.sv
module wol_magic_detect_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic       rx_sof,
    input logic       rx_eof,
    input logic       rx_crc_ok,
    input logic       magic_en,
    input logic [1:0] pwr_state,
    input logic       wake_clr,
    input logic       match_done,
    input logic       wake_flag
);
    AST_WAKE_NEEDS_CRC: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flag) |-> $past(rx_valid && rx_eof && rx_crc_ok)); // R3

    AST_WAKE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flag) |-> $past(match_done)); // R1

    AST_WAKE_POWER_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flag) |-> $past(pwr_state == 2'b01 || (pwr_state == 2'b00 && magic_en))); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wake_flag && !wake_clr) |=> wake_flag); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wake_clr && !(rx_valid && rx_eof)) |=> !wake_flag); // R8

    AST_SOF_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sof) |=> !match_done); // R9
endmodule

bind wol_magic_detect wol_magic_detect_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_sof     (rx_sof),
    .rx_eof     (rx_eof),
    .rx_crc_ok  (rx_crc_ok),
    .magic_en   (magic_en),
    .pwr_state  (pwr_state),
    .wake_clr   (wake_clr),
    .match_done (match_done),
    .wake_flag  (wake_flag)
);

// File: tb/wol_magic_detect_bench.sv
module wol_magic_detect_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid, rx_sof, rx_eof, rx_crc_ok;
    logic [7:0]  rx_byte;
    logic [47:0] station_addr;
    logic        magic_en;
    logic [1:0]  pwr_state;
    logic        wake_clr;
    logic        wake_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] frm [0:255];
    int         frm_len;

    always #5ns clk = ~clk;

    wol_magic_detect u_wol_magic_detect (
        .clk (clk), .rst (rst), .rx_valid (rx_valid), .rx_byte (rx_byte),
        .rx_sof (rx_sof), .rx_eof (rx_eof), .rx_crc_ok (rx_crc_ok),
        .station_addr (station_addr), .magic_en (magic_en), .pwr_state (pwr_state),
        .wake_clr (wake_clr), .wake_flag (wake_flag)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: wake_flag=%0b expected %0b", req, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        frm[frm_len] = b;
        frm_len++;
    endtask

    task automatic push_ff(input int n);
        for (int i = 0; i < n; i++) push(8'hFF);
    endtask

    task automatic push_addr_bytes(input int n);
        for (int i = 0; i < n; i++) push(station_addr[47 - 8*(i % 6) -: 8]);
    endtask

    task automatic push_copies(input int n);
        push_addr_bytes(6 * n);
    endtask

    task automatic open_frame(input int pre_n);
        frm_len = 0;
        push_addr_bytes(6);
        for (int i = 0; i < 6; i++) push(8'h10 + 8'(i));
        push(8'h08); push(8'h00);
        for (int i = 0; i < pre_n; i++) push(8'h5A);
    endtask

    task automatic send(input bit crc, input bit clr_at_eof);
        push(8'hC3); push(8'h7E); push(8'h91); push(8'h44);
        for (int i = 0; i < frm_len; i++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_byte   = frm[i];
            rx_sof    = (i == 0);
            rx_eof    = (i == frm_len - 1);
            rx_crc_ok = crc && (i == frm_len - 1);
            wake_clr  = clr_at_eof && (i == frm_len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0; wake_clr = 1'b0;
    endtask

    task automatic magic_frame(input int pre_n, input int ff_n, input int copies, input bit crc);
        open_frame(pre_n);
        push_ff(ff_n);
        push_copies(copies);
        send(crc, 1'b0);
    endtask

    task automatic pulse_clear();
        @(negedge clk); wake_clr = 1'b1;
        @(negedge clk); wake_clr = 1'b0;
        check(wake_flag, 1'b0, "R8 clear");
    endtask

    task automatic set_power(input logic [1:0] ps, input logic en);
        @(negedge clk); pwr_state = ps; magic_en = en;
    endtask

    task automatic t_reset();
        check(wake_flag, 1'b0, "R10 reset");
    endtask

    task automatic t_basic();
        set_power(2'b00, 1'b1);
        magic_frame(4, 6, 16, 1'b1);
        check(wake_flag, 1'b1, "R1 basic");
        check(wake_flag, 1'b1, "R4 full power enabled");
        pulse_clear();
    endtask

    task automatic t_offsets();
        magic_frame(40, 6, 16, 1'b1);
        check(wake_flag, 1'b1, "R7 late start");
        pulse_clear();
        magic_frame(0, 9, 16, 1'b1);
        check(wake_flag, 1'b1, "R7 long run");
        pulse_clear();
        magic_frame(2, 5, 16, 1'b1);
        check(wake_flag, 1'b0, "R1 five sync bytes");
    endtask

    task automatic t_incomplete();
        magic_frame(3, 6, 15, 1'b1);
        check(wake_flag, 1'b0, "R2 fifteen copies");
        open_frame(3);
        push_ff(6); push_copies(8); push(8'h00); push_copies(8);
        send(1'b1, 1'b0);
        check(wake_flag, 1'b0, "R2 gap");
    endtask

    task automatic t_crc();
        magic_frame(3, 6, 16, 1'b0);
        check(wake_flag, 1'b0, "R3 bad crc");
    endtask

    task automatic t_power();
        set_power(2'b00, 1'b0);
        magic_frame(3, 6, 16, 1'b1);
        check(wake_flag, 1'b0, "R4 full power disabled");
        set_power(2'b01, 1'b0);
        magic_frame(3, 6, 16, 1'b1);
        check(wake_flag, 1'b1, "R5 low power auto");
        pulse_clear();
        set_power(2'b10, 1'b1);
        magic_frame(3, 6, 16, 1'b1);
        check(wake_flag, 1'b0, "R6 state 10");
        set_power(2'b11, 1'b1);
        magic_frame(3, 6, 16, 1'b1);
        check(wake_flag, 1'b0, "R6 state 11");
        set_power(2'b00, 1'b1);
    endtask

    task automatic t_break();
        open_frame(2);
        push_ff(6); push_addr_bytes(3); push_ff(6); push_copies(16);
        send(1'b1, 1'b0);
        check(wake_flag, 1'b1, "R7 restart on ff");
        pulse_clear();
        open_frame(2);
        push_ff(6); push_addr_bytes(3); push_ff(5); push_copies(16);
        send(1'b1, 1'b0);
        check(wake_flag, 1'b0, "R7 restart counts from one");
    endtask

    task automatic t_sticky();
        magic_frame(1, 6, 16, 1'b1);
        check(wake_flag, 1'b1, "R8 set");
        open_frame(10);
        send(1'b1, 1'b0);
        check(wake_flag, 1'b1, "R8 sticky");
        repeat (5) @(negedge clk);
        check(wake_flag, 1'b1, "R8 sticky idle");
        pulse_clear();
        open_frame(1); push_ff(6); push_copies(16);
        send(1'b1, 1'b1);
        check(wake_flag, 1'b1, "R8 set beats clear");
        pulse_clear();
    endtask

    task automatic t_sof();
        magic_frame(2, 6, 16, 1'b0);
        check(wake_flag, 1'b0, "R9 first frame");
        open_frame(20);
        send(1'b1, 1'b0);
        check(wake_flag, 1'b0, "R9 no carry over");
    endtask

    initial begin
        rst = 1'b1; rx_valid = 1'b0; rx_byte = '0; rx_sof = 1'b0; rx_eof = 1'b0;
        rx_crc_ok = 1'b0; wake_clr = 1'b0; magic_en = 1'b1; pwr_state = 2'b00;
        station_addr = 48'h02_1A_3C_4D_5E_6F;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_offsets();
        t_incomplete();
        t_crc();
        t_power();
        t_break();
        t_sticky();
        t_sof();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1ms;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule